// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block stores an alarm time as six independent fields: seconds, minutes, hours, weekday, day of month and month (1 to 12). Each field carries a BCD value and its own compare-enable bit, so software can build the match condition from any subset of the six fields. Examples are "every day at 07:30:00" or "every Monday". There is no year field.

The calendar counters elsewhere in the chip present the live BCD time on a packed bus and pulse a one-cycle tick strobe at each seconds update. On that strobe the block compares every enabled field with the live time. When all enabled fields agree, it sets a sticky alarm flag. An interrupt output follows the flag, gated by an alarm interrupt enable.

Software uses a simple register write port and a combinational read port. To arm the alarm, software first writes the control register with both the flag and the enable at 0. It then writes the six fields and finally sets the enable.

Top module: `bcd_alarm_match`

## Requirements
- R1: After reset every alarm field reads 0x00, the control register reads 0x00 and the interrupt output is low.
- R2: Addresses 0 to 5 hold the seconds, minutes, hours, weekday, day and month fields, and each reads back its last written 8-bit value. Address 6 is control: flag at bit 0 and interrupt enable at bit 3, with every other bit reading 0. Address 7 reads 0 and ignores writes.
- R3: In each alarm field, bits 6:0 hold the BCD value and bit 7 enables the compare. A field whose bit 7 is 0 takes no part in the match, whatever its value. On `now_time_i`, field k sits at bits 7k+6:7k, with seconds at k=0 and month at k=5.
- R4: The match is evaluated only in a cycle with `tick_i` high. The flag is 1 from the clock edge that samples a tick with all enabled fields equal, and a match without a tick never sets it.
- R5: With no field enabled, the flag never sets, however the time and tick inputs behave.
- R6: The flag stays 1 until a write to address 6 with bit 0 equal to 0 clears it. A write with bit 0 equal to 1 leaves the flag unchanged, and software cannot set it.
- R7: `alarm_irq_o` is high exactly when both the flag and the interrupt enable are 1.
- R8: When a match on a tick and a control write that clears the flag fall on the same clock edge, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| tick_i | input | 1 | One-cycle seconds-update strobe |
| now_time_i | input | 42 | Live BCD time, six 7-bit fields, seconds lowest |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| alarm_irq_o | output | 1 | Alarm interrupt request |

## Verification
The bench programs all 64 enable subsets. For each subset it presents the exact alarm time, and then the same time with each single field disturbed in turn. This catches a design that compares disabled fields, ignores an enabled one, or matches when the mask is empty. A comparator that ran every cycle is caught because the bench holds a match with the tick low and then checks the flag. A design that lets software write 1 to the flag, or lets a same-edge clear beat a hardware set, shows the wrong flag value on readback. Swapping the flag and enable bit positions, or decoding an interrupt without the enable, shows up on the control readback and on `alarm_irq_o`.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int unsigned NUM_FIELDS = 6;
  localparam int unsigned CTRL_ADDR  = 6;
  localparam int unsigned FLAG_BIT   = 0;
  localparam int unsigned IE_BIT     = 3;
  localparam int unsigned CTRL_W     = 8;
endpackage

// File: rtl/alarm_field_slot.sv
module alarm_field_slot #(
  parameter int unsigned FIELD_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [FIELD_W:0]   wdata_i,
  input  logic [FIELD_W-1:0] now_i,
  output logic [FIELD_W:0]   reg_o,
  output logic               en_o,
  output logic               ok_o
);
  logic [FIELD_W:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   val_q <= '0;
    else if (wr_i) val_q <= wdata_i;
  end

  assign reg_o = val_q;
  assign en_o  = val_q[FIELD_W];
  // disabled field never blocks the match
  assign ok_o  = !val_q[FIELD_W] || (val_q[FIELD_W-1:0] == now_i);

  p_hold_without_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(val_q));
  p_disabled_field_ok_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_o[FIELD_W] |-> ok_o);
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl
  import bcd_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              set_i,
  output logic              flag_o,
  output logic              ie_o,
  output logic              irq_o
);
  logic flag_q, ie_q;
  logic sw_clr;

  assign sw_clr = ctrl_wr_i && !ctrl_wdata_i[FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      // hardware set wins over a same-edge software clear
      if (set_i)       flag_q <= 1'b1;
      else if (sw_clr) flag_q <= 1'b0;
      if (ctrl_wr_i)   ie_q   <= ctrl_wdata_i[IE_BIT];
    end
  end

  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign irq_o  = flag_q & ie_q;

  p_set_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !sw_clr) |=> flag_q);
  p_fall_needs_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(sw_clr));
  p_rise_needs_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_i));
  p_irq_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && ie_o));
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
  import bcd_alarm_pkg::*;
#(
  parameter int unsigned FIELD_W = 7,
  localparam int unsigned REG_W  = FIELD_W + 1,
  localparam int unsigned ADDR_W = $clog2(NUM_FIELDS + 2),
  localparam int unsigned TIME_W = NUM_FIELDS * FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] now_time_i,
  output logic              alarm_flag_o,
  output logic              alarm_irq_o
);
  logic [NUM_FIELDS-1:0] en_vec, ok_vec;
  logic [REG_W-1:0]      field_q [NUM_FIELDS];
  logic                  match, ie;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    alarm_field_slot #(.FIELD_W(FIELD_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && (wr_addr_i == ADDR_W'(k))),
      .wdata_i (wr_data_i),
      .now_i   (now_time_i[k*FIELD_W +: FIELD_W]),
      .reg_o   (field_q[k]),
      .en_o    (en_vec[k]),
      .ok_o    (ok_vec[k])
    );
  end

  // an empty mask must not match
  assign match = (&ok_vec) && (|en_vec);

  alarm_flag_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_wr_i    (wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR))),
    .ctrl_wdata_i (CTRL_W'(wr_data_i)),
    .set_i        (tick_i && match),
    .flag_o       (alarm_flag_o),
    .ie_o         (ie),
    .irq_o        (alarm_irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_addr_i) < NUM_FIELDS) begin
      rd_data_o = field_q[rd_addr_i];
    end else if (rd_addr_i == ADDR_W'(CTRL_ADDR)) begin
      rd_data_o[FLAG_BIT] = alarm_flag_o;
      rd_data_o[IE_BIT]   = ie;
    end
  end

  p_tick_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !$rose(alarm_flag_o));
  p_none_enabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_vec == '0) |=> !$rose(alarm_flag_o));
  p_irq_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_flag_o && ie) |-> alarm_irq_o);
endmodule

// File: tb/bcd_alarm_match_bench.sv
module bcd_alarm_match_bench;
  localparam int unsigned NF = 6;
  localparam int unsigned FW = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        tick = 1'b0;
  logic [NF*FW-1:0] now_time = '0;
  logic        flag, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [6:0] alarm_val [NF];

  always #5 clk = ~clk;

  bcd_alarm_match u_bcd_alarm_match (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tick_i(tick), .now_time_i(now_time), .alarm_flag_o(flag), .alarm_irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_time_exact();
    for (int k = 0; k < NF; k++) now_time[k*FW +: FW] = alarm_val[k];
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    alarm_val[0] = 7'h45; alarm_val[1] = 7'h37; alarm_val[2] = 7'h23;
    alarm_val[3] = 7'h06; alarm_val[4] = 7'h31; alarm_val[5] = 7'h12;

    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reset readback", d, 0);
    end
    check("R1 irq after reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: readback of fields, control masking, unused address
    for (int k = 0; k < NF; k++) wr(3'(k), 8'(8'h11 * (k + 1)) ^ 8'h80);
    for (int k = 0; k < NF; k++) begin
      rd(3'(k), d);
      check("R2 field readback", d, 8'(8'h11 * (k + 1)) ^ 8'h80);
    end
    wr(3'd6, 8'hFF);
    rd(3'd6, d);
    check("R2 control bits, R6 sw cannot set flag", d, 8'h08);
    wr(3'd7, 8'hA5);
    rd(3'd7, d);
    check("R2 address 7 reads zero", d, 0);
    wr(3'd6, 8'h00);
    rd(3'd6, d);
    check("R2 control cleared", d, 0);

    // R4: match held without tick does not set flag
    for (int k = 0; k < NF; k++) wr(3'(k), {1'b1, alarm_val[k]});
    set_time_exact();
    repeat (5) @(negedge clk);
    check("R4 no tick no flag", flag, 0);
    pulse_tick();
    check("R4 flag after tick", flag, 1);
    check("R7 irq low with enable 0", irq, 0);

    // R6: sticky, bit0=1 write keeps it, R7 irq
    now_time = '0;
    pulse_tick();
    check("R6 flag sticky after mismatch tick", flag, 1);
    wr(3'd6, 8'h09);
    check("R6 write bit0=1 keeps flag", flag, 1);
    check("R7 irq with flag and enable", irq, 1);
    rd(3'd6, d);
    check("R2 control readback flag+enable", d, 8'h09);
    wr(3'd6, 8'h08);
    check("R6 write bit0=0 clears flag", flag, 0);
    check("R7 irq low without flag", irq, 0);

    // R8: same-edge set and clear
    set_time_exact();
    wr(3'd6, 8'h09);
    pulse_tick();
    check("R8 setup flag", flag, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd6; wr_data = 8'h08; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    check("R8 hw set beats sw clear", flag, 1);
    wr(3'd6, 8'h00);
    check("R8 later clear works", flag, 0);

    // R3/R5: sweep all enable subsets, each field disturbed in turn
    for (int m = 0; m < 64; m++) begin
      for (int k = 0; k < NF; k++)
        wr(3'(k), {m[k], (m[k] ? alarm_val[k] : 7'(alarm_val[k] ^ 7'h7F))});
      for (int p = 0; p <= NF; p++) begin
        bit exp;
        set_time_exact();
        if (p < NF) now_time[p*FW +: FW] = alarm_val[p] ^ 7'h01;
        exp = (m != 0) && ((p == NF) || !m[p]);
        pulse_tick();
        if (m == 0) check("R5 empty mask never matches", flag, 0);
        else        check("R3 masked field compare", flag, exp);
        wr(3'd6, 8'h00);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule